// File: doc/BRIEF.md
# Paired-Core Lookup RAM

This block is the second, lookup-style word memory that sits beside one processing core. It stores 512 words of 32 bits and is only ever read or written as whole words. Its first port belongs to the owning core's load and store instructions. These instructions may present the location in two forms. One is a local index form, 0x000 to 0x1FF. The other is the position of the memory in the wider address map, 0x200 to 0x3FF. The block translates both forms to a row index.

Its second port has two users. The first is a mirrored write path from the partner core. The partner is the core whose ID differs from this one only in bit 0. When the owner has switched pairing on, every local write that the partner makes also lands here. The second user is a streaming engine that reads words through the same port. When both want the port in one clock, the accepted partner write is performed. The streamer's read is then reported as not valid for that cycle, and the streamer retries on its own.

Top module: `pairedLookupRam`

## Requirements
- R1: While `rstN` is low and on the first edge after it, `coreRdValid` and `strRdValid` are 0, and the pairing enable is cleared, so a partner write made right after reset leaves memory unchanged.
- R2: A port 1 access is in the window when `coreAddr[9]` equals `coreGlobal`. `coreGlobal`=0 selects the local form, with bit 9 = 0. `coreGlobal`=1 selects the map form, with bit 9 = 1. In both forms `coreAddr[8:0]` is the row. An access outside the window writes nothing, and its read returns `coreRdValid`=0.
- R3: A port 1 read in the window gives `coreRdValid`=1 and the row's contents one clock later. Those contents are the ones held before any write in the same cycle. Without such a read, `coreRdValid` is 0 and `coreRdData` holds its last value.
- R4: The pairing enable is written through `pairCfgWe` with the value `pairCfgData`. It takes effect from the next clock, so a partner write in the same cycle as the enable is set is ignored.
- R5: A partner write is accepted only when the pairing enable is set and `nbrId` equals `CORE_ID` with bit 0 inverted. Any other partner write leaves memory unchanged.
- R6: When an accepted partner write and a streamer read arrive in the same cycle, the write is performed. One clock later `strRdValid` is 0 and `strRdData` keeps its previous value.
- R7: A streamer read that is not blocked gives `strRdValid`=1 and the row's contents one clock later. Those contents are the ones held before any write in the same cycle.
- R8: When a port 1 write and an accepted partner write hit the same row in the same cycle, the port 1 data is stored.
- R9: A partner write that is rejected does not block a streamer read made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreRdEn | input | 1 | Port 1 read request |
| coreWrEn | input | 1 | Port 1 write request |
| coreGlobal | input | 1 | 1: `coreAddr` is in map form; 0: local form |
| coreAddr | input | 10 | Port 1 address |
| coreWrData | input | 32 | Port 1 write data |
| coreRdData | output | 32 | Port 1 read data |
| coreRdValid | output | 1 | Port 1 read data is fresh this cycle |
| pairCfgWe | input | 1 | Write strobe for the pairing enable |
| pairCfgData | input | 1 | New value of the pairing enable |
| nbrWrEn | input | 1 | Partner core mirrored write |
| nbrId | input | 3 | ID of the core issuing the mirrored write |
| nbrAddr | input | 9 | Row of the mirrored write |
| nbrWrData | input | 32 | Data of the mirrored write |
| strRdEn | input | 1 | Streamer read request |
| strAddr | input | 9 | Streamer read row |
| strRdData | output | 32 | Streamer read data |
| strRdValid | output | 1 | Streamer read was served |

## Verification
The assertions assume that every request input is driven to a known level on each clock edge after reset, and that the configuration strobe is idle during reset. The bench meets this by driving every input from one task, half a period away from the active edge. After each edge it returns all strobes to 0. The bench also writes every row through port 1 before it issues any read, so no read ever returns uninitialised contents. It draws rows from a narrow range so that the port collisions of R6, R8 and R9 happen often.

// File: rtl/lutPairPkg.sv
package lutPairPkg;
  // Per-cycle commands from control to the storage datapath.
  typedef struct packed {
    logic p1Rd;  // port 1 read, address inside window
    logic p1Wr;  // port 1 write, address inside window
    logic p2Wr;  // accepted partner mirrored write
    logic p2Rd;  // streamer read granted on port 2
  } lutStrobes_t;
endpackage

// File: rtl/pairLutCtrl.sv
module pairLutCtrl
  import lutPairPkg::*;
#(
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned ID_W    = 3,
  parameter int unsigned CORE_ID = 0,
  localparam int unsigned MAP_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreRdEn,
  input  logic             coreWrEn,
  input  logic             coreGlobal,
  input  logic [MAP_W-1:0] coreAddr,
  input  logic             pairCfgWe,
  input  logic             pairCfgData,
  input  logic             nbrWrEn,
  input  logic [ID_W-1:0]  nbrId,
  input  logic             strRdEn,
  output lutStrobes_t      strobes,
  output logic [IDX_W-1:0] p1Idx
);
  localparam logic [ID_W-1:0] PARTNER_ID = ID_W'(CORE_ID) ^ ID_W'(1);

  logic pairEnQ;
  logic windowHit;
  logic nbrAccept;

  always_ff @(posedge clk) begin
    if (!rstN)          pairEnQ <= 1'b0;
    else if (pairCfgWe) pairEnQ <= pairCfgData;
  end

  // Top address bit distinguishes the two address forms.
  assign windowHit = (coreAddr[MAP_W-1] == coreGlobal);
  assign p1Idx     = coreAddr[IDX_W-1:0];
  assign nbrAccept = nbrWrEn && pairEnQ && (nbrId == PARTNER_ID);

  always_comb begin
    strobes.p1Rd = coreRdEn && windowHit;
    strobes.p1Wr = coreWrEn && windowHit;
    strobes.p2Wr = nbrAccept;
    strobes.p2Rd = strRdEn && !nbrAccept;  // write owns port 2
  end

  AST_WINDOW_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (coreGlobal != coreAddr[MAP_W-1]) |-> !(strobes.p1Rd || strobes.p1Wr)); // R2
  AST_PAIR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $past(pairCfgWe && !pairCfgData) |-> !strobes.p2Wr); // R4
  AST_FOREIGN_ID: assert property (@(posedge clk) disable iff (!rstN)
    (nbrWrEn && nbrId != PARTNER_ID) |-> !strobes.p2Wr); // R5
  AST_IDLE_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    (strRdEn && !nbrWrEn) |-> strobes.p2Rd); // R9
endmodule

// File: rtl/pairLutData.sv
module pairLutData
  import lutPairPkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lutStrobes_t       strobes,
  input  logic [IDX_W-1:0]  p1Idx,
  input  logic [WORD_W-1:0] coreWrData,
  input  logic [IDX_W-1:0]  nbrAddr,
  input  logic [WORD_W-1:0] nbrWrData,
  input  logic [IDX_W-1:0]  strAddr,
  output logic [WORD_W-1:0] coreRdData,
  output logic              coreRdValid,
  output logic [WORD_W-1:0] strRdData,
  output logic              strRdValid
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Port 1 write is issued last so it overrides a same-row partner write.
  always_ff @(posedge clk) begin
    if (strobes.p2Wr) mem[nbrAddr] <= nbrWrData;
    if (strobes.p1Wr) mem[p1Idx]   <= coreWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreRdData  <= '0;
      coreRdValid <= 1'b0;
      strRdData   <= '0;
      strRdValid  <= 1'b0;
    end else begin
      coreRdValid <= strobes.p1Rd;
      strRdValid  <= strobes.p2Rd;
      if (strobes.p1Rd) coreRdData <= mem[p1Idx];
      if (strobes.p2Rd) strRdData  <= mem[strAddr];
    end
  end

  AST_P1_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.p1Rd |=> coreRdValid); // R3
  AST_P1_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.p1Rd |=> (!coreRdValid && $stable(coreRdData))); // R3
  AST_P2_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.p2Wr |=> (!strRdValid && $stable(strRdData))); // R6
  AST_P2_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobes.p2Rd |=> strRdValid); // R7
  AST_P1_OVERRIDES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.p1Wr && strobes.p2Wr && p1Idx == nbrAddr)
      |=> (mem[$past(p1Idx)] == $past(coreWrData))); // R8
endmodule

// File: rtl/pairedLookupRam.sv
module pairedLookupRam
  import lutPairPkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned ID_W    = 3,
  parameter int unsigned CORE_ID = 0,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned MAP_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreRdEn,
  input  logic              coreWrEn,
  input  logic              coreGlobal,
  input  logic [MAP_W-1:0]  coreAddr,
  input  logic [WORD_W-1:0] coreWrData,
  output logic [WORD_W-1:0] coreRdData,
  output logic              coreRdValid,
  input  logic              pairCfgWe,
  input  logic              pairCfgData,
  input  logic              nbrWrEn,
  input  logic [ID_W-1:0]   nbrId,
  input  logic [IDX_W-1:0]  nbrAddr,
  input  logic [WORD_W-1:0] nbrWrData,
  input  logic              strRdEn,
  input  logic [IDX_W-1:0]  strAddr,
  output logic [WORD_W-1:0] strRdData,
  output logic              strRdValid
);
  lutStrobes_t      strobes;
  logic [IDX_W-1:0] p1Idx;

  pairLutCtrl #(
    .IDX_W(IDX_W), .ID_W(ID_W), .CORE_ID(CORE_ID)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .coreRdEn(coreRdEn), .coreWrEn(coreWrEn),
    .coreGlobal(coreGlobal), .coreAddr(coreAddr),
    .pairCfgWe(pairCfgWe), .pairCfgData(pairCfgData),
    .nbrWrEn(nbrWrEn), .nbrId(nbrId), .strRdEn(strRdEn),
    .strobes(strobes), .p1Idx(p1Idx)
  );

  pairLutData #(
    .WORD_W(WORD_W), .DEPTH(DEPTH)
  ) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .p1Idx(p1Idx),
    .coreWrData(coreWrData), .nbrAddr(nbrAddr), .nbrWrData(nbrWrData),
    .strAddr(strAddr), .coreRdData(coreRdData), .coreRdValid(coreRdValid),
    .strRdData(strRdData), .strRdValid(strRdValid)
  );
endmodule

// File: tb/tb_pairedLookupRam.sv
module tb_pairedLookupRam;
  localparam int unsigned CORE_ID = 5;
  localparam logic [2:0]  NBR_ID  = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreRdEn = 0, coreWrEn = 0, coreGlobal = 0;
  logic [9:0]  coreAddr = '0;
  logic [31:0] coreWrData = '0;
  logic [31:0] coreRdData;
  logic        coreRdValid;
  logic pairCfgWe = 0, pairCfgData = 0, nbrWrEn = 0, strRdEn = 0;
  logic [2:0]  nbrId = '0;
  logic [8:0]  nbrAddr = '0, strAddr = '0;
  logic [31:0] nbrWrData = '0;
  logic [31:0] strRdData;
  logic        strRdValid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] mdl [512];
  bit          mdlPair = 0;
  logic [31:0] expCD = '0, expSD = '0;
  logic        expCV = 0, expSV = 0;

  always #2 clk = ~clk;

  pairedLookupRam #(.CORE_ID(CORE_ID)) dut (
    .clk(clk), .rstN(rstN), .coreRdEn(coreRdEn), .coreWrEn(coreWrEn),
    .coreGlobal(coreGlobal), .coreAddr(coreAddr), .coreWrData(coreWrData),
    .coreRdData(coreRdData), .coreRdValid(coreRdValid),
    .pairCfgWe(pairCfgWe), .pairCfgData(pairCfgData), .nbrWrEn(nbrWrEn),
    .nbrId(nbrId), .nbrAddr(nbrAddr), .nbrWrData(nbrWrData),
    .strRdEn(strRdEn), .strAddr(strAddr), .strRdData(strRdData),
    .strRdValid(strRdValid)
  );

  function automatic logic [31:0] seed(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0001_0003;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: update the behavioural model, cross the edge, compare, idle inputs.
  task automatic tick();
    bit inWin, nbrOk;
    int idx;
    inWin = (coreAddr[9] == coreGlobal);
    idx   = int'(coreAddr[8:0]);
    nbrOk = nbrWrEn && mdlPair && (nbrId == NBR_ID);
    expCV = coreRdEn && inWin;
    if (expCV) expCD = mdl[idx];
    expSV = strRdEn && !nbrOk;
    if (expSV) expSD = mdl[int'(strAddr)];
    if (nbrOk) mdl[int'(nbrAddr)] = nbrWrData;
    if (coreWrEn && inWin) mdl[idx] = coreWrData;
    if (pairCfgWe) mdlPair = pairCfgData;
    @(posedge clk);
    @(negedge clk);
    check(coreRdValid === expCV, "R2 R3 model coreRdValid", 32'(coreRdValid), 32'(expCV));
    check(coreRdData === expCD, "R3 model coreRdData", coreRdData, expCD);
    check(strRdValid === expSV, "R6 R7 R9 model strRdValid", 32'(strRdValid), 32'(expSV));
    check(strRdData === expSD, "R6 R7 model strRdData", strRdData, expSD);
    coreRdEn = 0; coreWrEn = 0; pairCfgWe = 0; nbrWrEn = 0; strRdEn = 0;
  endtask

  task automatic coreRead(input logic glob, input logic [9:0] a);
    coreRdEn = 1; coreGlobal = glob; coreAddr = a;
  endtask
  task automatic coreWrite(input logic glob, input logic [9:0] a, input logic [31:0] d);
    coreWrEn = 1; coreGlobal = glob; coreAddr = a; coreWrData = d;
  endtask
  task automatic nbrWrite(input logic [2:0] id, input logic [8:0] a, input logic [31:0] d);
    nbrWrEn = 1; nbrId = id; nbrAddr = a; nbrWrData = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(coreRdValid === 1'b0 && strRdValid === 1'b0, "R1 valids in reset",
          {coreRdValid, strRdValid}, 32'd0);
    rstN = 1;
    tick();
    check(coreRdValid === 1'b0 && strRdValid === 1'b0, "R1 valids after reset",
          {coreRdValid, strRdValid}, 32'd0);

    for (int i = 0; i < 512; i++) begin
      coreWrite(1'b0, 10'(i), seed(i));
      tick();
    end

    // R1 R4: pairing is off after reset, partner write dropped
    nbrWrite(NBR_ID, 9'd3, 32'hDEAD_0003); tick();
    coreRead(1'b0, 10'd3); tick();
    check(coreRdData === seed(3), "R1 R4 pairing clear at reset", coreRdData, seed(3));

    // R2: map form write, local form read
    coreWrite(1'b1, 10'h205, 32'h2222_2222); tick();
    coreRead(1'b0, 10'h005); tick();
    check(coreRdData === 32'h2222_2222, "R2 map-form write", coreRdData, 32'h2222_2222);
    coreRead(1'b1, 10'h005); tick();
    check(coreRdValid === 1'b0, "R2 map-form read outside window", 32'(coreRdValid), 32'd0);
    coreWrite(1'b0, 10'h207, 32'hBAD0_0007); tick();
    coreRead(1'b1, 10'h207); tick();
    check(coreRdData === seed(7), "R2 out-of-window write dropped", coreRdData, seed(7));

    // R3: read sees old contents; hold afterwards
    coreWrite(1'b0, 10'd10, 32'h3333_3333); coreRdEn = 1; tick();
    check(coreRdValid === 1'b1 && coreRdData === seed(10), "R3 read before write", coreRdData, seed(10));
    tick();
    check(coreRdValid === 1'b0 && coreRdData === seed(10), "R3 hold", coreRdData, seed(10));

    // R4: enable effective from next cycle
    pairCfgWe = 1; pairCfgData = 1; nbrWrite(NBR_ID, 9'd20, 32'h4444_4444); tick();
    coreRead(1'b0, 10'd20); tick();
    check(coreRdData === seed(20), "R4 same-cycle enable ignored", coreRdData, seed(20));
    nbrWrite(NBR_ID, 9'd21, 32'h4545_4545); tick();
    coreRead(1'b0, 10'd21); tick();
    check(coreRdData === 32'h4545_4545, "R4 R5 partner write accepted", coreRdData, 32'h4545_4545);

    // R5: wrong IDs rejected
    nbrWrite(3'(CORE_ID), 9'd22, 32'h5555_0022); tick();
    nbrWrite(3'd6, 9'd23, 32'h5555_0023); tick();
    coreRead(1'b0, 10'd22); tick();
    check(coreRdData === seed(22), "R5 own ID rejected", coreRdData, seed(22));
    coreRead(1'b0, 10'd23); tick();
    check(coreRdData === seed(23), "R5 unpaired ID rejected", coreRdData, seed(23));

    // R7: plain streamer read
    strRdEn = 1; strAddr = 9'd21; tick();
    check(strRdValid === 1'b1 && strRdData === 32'h4545_4545, "R7 streamer read", strRdData, 32'h4545_4545);

    // R6: accepted write blocks streamer
    strRdEn = 1; strAddr = 9'd30; nbrWrite(NBR_ID, 9'd31, 32'h6666_6666); tick();
    check(strRdValid === 1'b0, "R6 streamer blocked", 32'(strRdValid), 32'd0);
    check(strRdData === 32'h4545_4545, "R6 streamer data held", strRdData, 32'h4545_4545);
    coreRead(1'b0, 10'd31); tick();
    check(coreRdData === 32'h6666_6666, "R6 blocking write stored", coreRdData, 32'h6666_6666);

    // R9: rejected write does not block
    strRdEn = 1; strAddr = 9'd30; nbrWrite(3'd7, 9'd31, 32'h9999_9999); tick();
    check(strRdValid === 1'b1 && strRdData === seed(30), "R9 streamer not blocked", strRdData, seed(30));

    // R8: port 1 wins a same-row write collision
    coreWrite(1'b0, 10'd40, 32'h8888_8888); nbrWrite(NBR_ID, 9'd40, 32'h7777_7777); tick();
    coreRead(1'b0, 10'd40); tick();
    check(coreRdData === 32'h8888_8888, "R8 port 1 priority", coreRdData, 32'h8888_8888);

    // Mixed traffic on a narrow row range, compared against the model each clock.
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      coreRdEn   = r[0];
      coreWrEn   = r[1] & r[2];
      coreGlobal = r[3];
      coreAddr   = {(r[6:4] == 3'd0) ? ~r[3] : r[3], 5'd0, r[10:7]};
      coreWrData = $urandom;
      nbrWrEn    = r[11];
      nbrId      = r[12] ? NBR_ID : 3'(r[15:13]);
      nbrAddr    = {5'd0, r[19:16]};
      nbrWrData  = $urandom;
      strRdEn    = r[20];
      strAddr    = {5'd0, r[24:21]};
      pairCfgWe  = (r[28:25] == 4'd0);
      pairCfgData = r[29];
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule